// File: doc/BRIEF.md
# Linked-list DMA channel sequencer

This block is one DMA channel that moves a transfer made of several buffers. Every buffer reads its words from the same source region: the source address goes back to its programmed starting value for each buffer. The destination address and the control words of each buffer come from a chain of descriptors in memory. Before the first buffer, software programs the source start address and a pointer to the first descriptor, then sets the enable bit. From that point the channel fetches a descriptor and clears the descriptor's done flag in memory. It copies the buffer one word at a time, reading a word and then writing it. It then writes the first control word back into the descriptor with the done flag set and the count of words it moved.

A next-descriptor pointer of zero marks the last buffer. When that buffer ends, the channel raises its transfer-complete interrupt and clears its own enable bit. Every buffer, the last one included, raises the buffer-complete interrupt. Software can learn of progress in three ways: from the interrupt levels, from the done flag of each descriptor in memory, or by watching the enable status fall. A single request port carries descriptor reads, status writes and data moves, and only one request is outstanding at a time.

Register map (word select `regAddr`): 0 holds the source start address. 1 holds the first descriptor pointer. 2 is the control register, where bit 0 = 1 enables the channel. 3 clears interrupts: writing a 1 to bit 0 clears buffer-complete, and writing a 1 to bit 1 clears transfer-complete. A descriptor at byte address P has this layout: P+0 is a source word that the channel never reads, P+4 is the destination address, P+8 is control word A and P+12 is control word B. P+16 holds the next-descriptor pointer. Control word A carries the word count in bits [15:0], a tag field in bits [30:16] and the done flag in bit 31. Bit 0 of control word B, when set, holds the destination address fixed; when clear, the destination steps by 4 for each word.

Top module: `lldma_chan`

## Requirements
- R1: While reset is asserted and right after it is released, chanEnabled, bufDoneIrq, xferDoneIrq and memReqValid are all 0.
- R2: On enable, and after each buffer that is not the last, the channel reads the descriptor words at P+4, P+8, P+12 and P+16, in that order. P is the first-descriptor register for the first buffer and the fetched next pointer for later buffers. The word at P+0 is never read.
- R3: Before the first data read of a buffer, the channel writes P+8 with bit 31 = 0 and bits [30:0] equal to the fetched control word A.
- R4: For word i of a buffer (i counted from 0), the channel reads address S+4i and then writes the returned data to D+4i, or to D when control word B bit 0 is 1. Here S is the source start address and D is the fetched destination address.
- R5: Every buffer begins reading at the programmed source start address, whatever addresses the previous buffer reached.
- R6: After the last word of a buffer, the channel writes P+8 once with bit 31 = 1, bits [30:16] unchanged and bits [15:0] equal to the number of words moved. No other descriptor word is ever written.
- R7: bufDoneIrq becomes 1 in the cycle after the final write-back of each buffer is accepted. It stays 1 until a write to register 3 with bit 0 set. That write leaves xferDoneIrq unchanged.
- R8: When the buffer whose next pointer is 0 completes, xferDoneIrq becomes 1 and chanEnabled becomes 0 at the same time, and the channel issues no further requests. xferDoneIrq clears only when register 3 is written with bit 1 set.
- R9: Writing the enable bit while the channel is enabled does not restart it or change its sequence of requests.
- R10: A descriptor with a word count of 0 moves no data. Its clear write is followed directly by a write-back with the done flag set and a count of 0.
- R11: A request that is not accepted stays valid, with the same address, direction and write data, until memReqReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register word select |
| regWrData | input | DATA_W | Register write data |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | DATA_W | Request byte address |
| memReqWData | output | DATA_W | Write data |
| memRspValid | input | 1 | One-cycle read data valid |
| memRspData | input | DATA_W | Read data |
| chanEnabled | output | 1 | Channel enable status |
| bufDoneIrq | output | 1 | Buffer-complete interrupt level |
| xferDoneIrq | output | 1 | Transfer-complete interrupt level |

## Verification
The bench builds the channel with its default parameters: 32-bit words and addresses, a 16-bit word count and a 2-bit register select. A 1 KB memory model holds several descriptors, their source region and their destinations. Buffer sizes of 0 to 4 words keep each run short and still reach the zero-count case, the single-word case, where the first word is also the last, and the fixed-destination mode. The model's ready signal is low one cycle in three, so requests must be held while stalled and each read response arrives one cycle after acceptance.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  typedef enum logic [1:0] {SEL_DESC, SEL_CTRLA, SEL_SRC, SEL_DST} memSel_e;

  typedef struct packed {
    logic       start;
    logic       capDesc;
    logic [1:0] descIdx;
    logic       bufBegin;
    logic       rdDone;
    logic       wrDone;
    logic       nextDesc;
    logic       wbFinal;
    memSel_e    sel;
  } strobes_t;
endpackage

// File: rtl/lldma_dp.sv
module lldma_dp
  import lldma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busy,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] memRspData,
  output logic [DATA_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWData,
  output logic              sizeZero,
  output logic              lastWord,
  output logic              chainEnd
);
  localparam int STEP = DATA_W / 8;
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

  logic [DATA_W-1:0] srcInit, headPtr, descPtr, srcCur, dstCur, ctrlA, nextPtr, dataBuf;
  logic              dstFixed;
  logic [CNT_W-1:0]  moved;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcInit  <= '0;
      headPtr  <= '0;
      descPtr  <= '0;
      srcCur   <= '0;
      dstCur   <= '0;
      ctrlA    <= '0;
      nextPtr  <= '0;
      dataBuf  <= '0;
      dstFixed <= 1'b0;
      moved    <= '0;
    end else begin
      if (regWrEn && !busy && regAddr == REG_AW'(0)) srcInit <= regWrData;
      if (regWrEn && !busy && regAddr == REG_AW'(1)) headPtr <= regWrData;
      if (stb.start) descPtr <= headPtr;
      if (stb.capDesc) begin
        case (stb.descIdx)
          2'd0:    dstCur   <= memRspData;
          2'd1:    ctrlA    <= memRspData;
          2'd2:    dstFixed <= memRspData[0];
          default: nextPtr  <= memRspData;
        endcase
      end
      if (stb.bufBegin) begin
        srcCur <= srcInit;
        moved  <= '0;
      end
      if (stb.rdDone) begin
        dataBuf <= memRspData;
        srcCur  <= srcCur + STEP_V;
      end
      if (stb.wrDone) begin
        dstCur <= dstFixed ? dstCur : dstCur + STEP_V;
        moved  <= moved + CNT_W'(1);
      end
      if (stb.nextDesc) descPtr <= nextPtr;
    end
  end

  always_comb begin
    memReqWData = dataBuf;
    case (stb.sel)
      SEL_DESC:  memReqAddr = descPtr + (DATA_W'(stb.descIdx) + DATA_W'(1)) * STEP_V;
      SEL_CTRLA: begin
        memReqAddr  = descPtr + DATA_W'(2 * STEP);
        memReqWData = stb.wbFinal ? {1'b1, ctrlA[DATA_W-2:CNT_W], moved}
                                  : {1'b0, ctrlA[DATA_W-2:0]};
      end
      SEL_SRC:   memReqAddr = srcCur;
      default:   memReqAddr = dstCur;
    endcase
  end

  assign sizeZero = (ctrlA[CNT_W-1:0] == '0);
  assign lastWord = ((CNT_W+1)'(moved) + (CNT_W+1)'(1)) == (CNT_W+1)'(ctrlA[CNT_W-1:0]);
  assign chainEnd = (nextPtr == '0);
endmodule

// File: rtl/lldma_ctl.sv
module lldma_ctl
  import lldma_pkg::*;
#(
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [1:0]        regBits,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic              sizeZero,
  input  logic              lastWord,
  input  logic              chainEnd,
  output strobes_t          stb,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic              chanEnabled,
  output logic              bufDoneIrq,
  output logic              xferDoneIrq
);
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_CLR, ST_RD, ST_WR, ST_WB} state_e;

  state_e     state;
  logic       waitRsp;
  logic [1:0] idx;
  logic       accept, enWrite, clrWrite;

  assign enWrite  = regWrEn && regAddr == REG_AW'(2) && regBits[0];
  assign clrWrite = regWrEn && regAddr == REG_AW'(3);

  always_comb begin
    stb         = '0;
    stb.sel     = SEL_DESC;
    stb.descIdx = idx;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    case (state)
      ST_FETCH: memReqValid = !waitRsp;
      ST_CLR: begin
        stb.sel = SEL_CTRLA;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
      end
      ST_RD: begin
        stb.sel = SEL_SRC;
        memReqValid = !waitRsp;
      end
      ST_WR: begin
        stb.sel = SEL_DST;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
      end
      ST_WB: begin
        stb.sel = SEL_CTRLA;
        stb.wbFinal = 1'b1;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
      end
      default: ;
    endcase
    accept       = memReqValid && memReqReady;
    stb.start    = (state == ST_IDLE) && enWrite;
    stb.capDesc  = (state == ST_FETCH) && waitRsp && memRspValid;
    stb.bufBegin = (state == ST_CLR) && accept;
    stb.rdDone   = (state == ST_RD) && waitRsp && memRspValid;
    stb.wrDone   = (state == ST_WR) && accept;
    stb.nextDesc = (state == ST_WB) && accept && !chainEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      waitRsp     <= 1'b0;
      idx         <= '0;
      bufDoneIrq  <= 1'b0;
      xferDoneIrq <= 1'b0;
    end else begin
      if (clrWrite && regBits[0]) bufDoneIrq  <= 1'b0;
      if (clrWrite && regBits[1]) xferDoneIrq <= 1'b0;
      if (accept && !memReqWrite) waitRsp <= 1'b1;
      case (state)
        ST_IDLE: if (stb.start) begin
          state <= ST_FETCH;
          idx   <= '0;
        end
        ST_FETCH: if (stb.capDesc) begin
          waitRsp <= 1'b0;
          idx     <= idx + 2'd1;
          if (idx == 2'd3) state <= ST_CLR;
        end
        ST_CLR: if (accept) state <= sizeZero ? ST_WB : ST_RD;
        ST_RD: if (stb.rdDone) begin
          waitRsp <= 1'b0;
          state   <= ST_WR;
        end
        ST_WR: if (accept) state <= lastWord ? ST_WB : ST_RD;
        ST_WB: if (accept) begin
          bufDoneIrq <= 1'b1;
          idx        <= '0;
          if (chainEnd) begin
            xferDoneIrq <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign chanEnabled = (state != ST_IDLE);
endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [DATA_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWData,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic              chanEnabled,
  output logic              bufDoneIrq,
  output logic              xferDoneIrq
);
  strobes_t stb;
  logic     sizeZero, lastWord, chainEnd;

  lldma_ctl #(.REG_AW(REG_AW)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regBits(regWrData[1:0]), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .sizeZero(sizeZero), .lastWord(lastWord), .chainEnd(chainEnd), .stb(stb),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .chanEnabled(chanEnabled),
    .bufDoneIrq(bufDoneIrq), .xferDoneIrq(xferDoneIrq)
  );

  lldma_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .busy(chanEnabled), .stb(stb), .memRspData(memRspData),
    .memReqAddr(memReqAddr), .memReqWData(memReqWData), .sizeZero(sizeZero),
    .lastWord(lastWord), .chainEnd(chainEnd)
  );
endmodule

// File: rtl/lldma_chk.sv
module lldma_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [DATA_W-1:0] memReqAddr,
  input logic [DATA_W-1:0] memReqWData,
  input logic              chanEnabled,
  input logic              bufDoneIrq,
  input logic              xferDoneIrq
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)
      && $stable(memReqWrite) && $stable(memReqWData));

  p_bufirq_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufDoneIrq) |-> $past(memReqValid && memReqReady && memReqWrite));

  p_end_disables_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferDoneIrq) |-> !chanEnabled && $past(chanEnabled));

  p_end_with_buf_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferDoneIrq) |-> bufDoneIrq);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnabled |-> !memReqValid);
endmodule

bind lldma_chan lldma_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqWData(memReqWData),
  .chanEnabled(chanEnabled), .bufDoneIrq(bufDoneIrq), .xferDoneIrq(xferDoneIrq)
);

// File: tb/sim_lldma_chan.sv
module sim_lldma_chan;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        memReqValid, memReqWrite, chanEnabled, bufDoneIrq, xferDoneIrq;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr, memReqWData;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  always #2 clk = ~clk;

  lldma_chan u0 (.*);

  int checks = 0, failures = 0, cyc = 0, holdErr = 0, holdSeen = 0;
  logic [31:0] mem [256];
  logic        rspDue = 1'b0;
  logic [31:0] rspWord = '0;
  logic        prevStall = 1'b0;
  logic [31:0] prevAddr = '0;

  logic        logW [64];
  logic [31:0] logA [64], logD [64];
  int          logN = 0;
  logic        expW [64];
  logic [31:0] expA [64], expD [64];
  string       expTag [64];
  int          expN = 0;

  // chain table: [31:16] destination, [15:8] word count, [0] fixed destination
  localparam int NBUF = 3;
  localparam logic [31:0] BUF_TAB [NBUF] = '{32'h0200_0300, 32'h0280_0100, 32'h0300_0401};
  localparam logic [31:0] SRC0 = 32'h40;

  function automatic logic [31:0] srcPat(logic [31:0] a);
    return 32'hA500_0000 + a;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushExp(logic w, logic [31:0] a, logic [31:0] d, string tag);
    expW[expN] = w; expA[expN] = a; expD[expN] = d; expTag[expN] = tag; expN++;
  endtask

  task automatic buildDesc(int k, logic [31:0] p, logic [31:0] dst, int size,
                           logic fixd, logic [31:0] nxt);
    logic [31:0] ca;
    ca = {1'b1, 15'(15'h1230 + k), 16'(size)};
    mem[p[9:2]]     = 32'hDEAD_BEEF;
    mem[p[9:2] + 1] = dst;
    mem[p[9:2] + 2] = ca;
    mem[p[9:2] + 3] = {31'b0, fixd};
    mem[p[9:2] + 4] = nxt;
    for (int j = 1; j <= 4; j++) pushExp(1'b0, p + 32'(4 * j), 32'h0, "R2");
    pushExp(1'b1, p + 8, {1'b0, ca[30:0]}, "R3");
    for (int i = 0; i < size; i++) begin
      pushExp(1'b0, SRC0 + 32'(4 * i), 32'h0, (k > 0) ? "R5" : "R4");
      pushExp(1'b1, fixd ? dst : dst + 32'(4 * i), srcPat(SRC0 + 32'(4 * i)),
              (size == 0) ? "R10" : "R4");
    end
    pushExp(1'b1, p + 8, {1'b1, ca[30:16], 16'(size)}, (size == 0) ? "R10" : "R6");
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rspDue) begin
      memRspValid = 1'b1; memRspData = rspWord; rspDue = 1'b0;
    end else begin
      memRspValid = 1'b0;
    end
    memReqReady = (cyc % 3) != 1;
    if (prevStall) begin
      holdSeen++;
      if (!memReqValid || memReqAddr !== prevAddr) holdErr++;
    end
    if (memReqValid && memReqReady) begin
      if (logN < 64) begin
        logW[logN] = memReqWrite; logA[logN] = memReqAddr; logD[logN] = memReqWData;
      end
      logN++;
      if (memReqWrite) mem[memReqAddr[9:2]] = memReqWData;
      else begin rspDue = 1'b1; rspWord = mem[memReqAddr[9:2]]; end
    end
    prevStall = memReqValid && !memReqReady;
    prevAddr  = memReqAddr;
  end

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    #1 regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (chanEnabled && n < 5000) begin @(negedge clk); n++; end
    check("R8 channel stops", 32'(chanEnabled), 32'h0);
    repeat (4) @(negedge clk);
  endtask

  task automatic compareLog();
    check("R9 request count", 32'(logN), 32'(expN));
    for (int i = 0; i < expN && i < logN; i++) begin
      check(expTag[i], {31'b0, logW[i]}, {31'b0, expW[i]});
      check(expTag[i], logA[i], expA[i]);
      if (expW[i]) check(expTag[i], logD[i], expD[i]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = srcPat(32'(4 * i));
    repeat (3) @(negedge clk);
    // R1: reset state, during and after reset
    check("R1 enable in reset", 32'(chanEnabled), 0);
    check("R1 req in reset", 32'(memReqValid), 0);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 enable", 32'(chanEnabled), 0);
    check("R1 bufirq", 32'(bufDoneIrq), 0);
    check("R1 xferirq", 32'(xferDoneIrq), 0);
    check("R1 req", 32'(memReqValid), 0);

    // chain from the table
    expN = 0;
    for (int k = 0; k < NBUF; k++)
      buildDesc(k, 32'h100 + 32'(32 * k), {16'h0, BUF_TAB[k][31:16]}, int'(BUF_TAB[k][15:8]),
                BUF_TAB[k][0], (k < NBUF - 1) ? 32'h100 + 32'(32 * (k + 1)) : 32'h0);
    regWrite(2'd0, SRC0);
    regWrite(2'd1, 32'h100);
    logN = 0;
    regWrite(2'd2, 32'h1);
    check("R8 enabled after start", 32'(chanEnabled), 1);
    repeat (6) @(negedge clk);
    regWrite(2'd2, 32'h1); // R9: enable again while running
    waitIdle();
    compareLog();
    for (int k = 0; k < NBUF; k++) begin
      check("R6 dst word kept", mem[(32'h100 + 32 * k + 4) >> 2], {16'h0, BUF_TAB[k][31:16]});
      check("R6 ctrlB kept", mem[(32'h100 + 32 * k + 12) >> 2], {31'b0, BUF_TAB[k][0]});
      check("R6 source word kept", mem[(32'h100 + 32 * k) >> 2], 32'hDEAD_BEEF);
      check("R6 done flag in memory", mem[(32'h100 + 32 * k + 8) >> 2],
            {1'b1, 15'(15'h1230 + k), 8'h0, BUF_TAB[k][15:8]});
    end
    check("R4 fixed destination holds last word", mem[32'h300 >> 2], srcPat(SRC0 + 12));
    check("R4 incrementing destination", mem[(32'h200 + 8) >> 2], srcPat(SRC0 + 8));
    check("R7 bufirq level", 32'(bufDoneIrq), 1);
    check("R8 xferirq level", 32'(xferDoneIrq), 1);
    regWrite(2'd3, 32'h1);
    @(negedge clk);
    check("R7 bufirq cleared", 32'(bufDoneIrq), 0);
    check("R7 xferirq untouched", 32'(xferDoneIrq), 1);
    regWrite(2'd3, 32'h2);
    @(negedge clk);
    check("R8 xferirq cleared", 32'(xferDoneIrq), 0);

    // R10: single descriptor with zero count
    expN = 0;
    mem[32'h380 >> 2] = 32'h5555_AAAA;
    buildDesc(7, 32'h1C0, 32'h380, 0, 1'b0, 32'h0);
    regWrite(2'd1, 32'h1C0);
    logN = 0;
    regWrite(2'd2, 32'h1);
    waitIdle();
    compareLog();
    check("R10 destination untouched", mem[32'h380 >> 2], 32'h5555_AAAA);
    check("R10 write-back word", mem[(32'h1C0 + 8) >> 2], {1'b1, 15'(15'h1237), 16'h0});
    check("R8 xferirq after single", 32'(xferDoneIrq), 1);
    check("R7 bufirq after single", 32'(bufDoneIrq), 1);
    check("R11 stalls observed", 32'(holdSeen > 0), 1);
    check("R11 request held while stalled", 32'(holdErr), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule